// File: doc/BRIEF.md
# Warp Branch Divergence Stack

This block holds the control-flow state of a single warp in a SIMT core. It supplies the program counter that fetch should use next and the set of lanes that may commit results. When a branch resolves with lanes that disagree, the block runs the two paths one after the other. Each path runs under its own subset of lanes. At the immediate post-dominator of the branch, called the reconvergence PC, the two paths merge again under the lane set that was active before the branch.

Each stack level records three things: a resume PC, a reconvergence PC (with a valid bit), and a lane mask. The top level is the one that executes. For an ordinary instruction, fetch reports the PC that follows it. For a branch, the execute stage reports the per-lane taken bits, the taken target, the fall-through PC and the reconvergence PC. All outputs are registered, so an event presented in one cycle appears on the outputs after the next rising clock edge.

Top module: `simt_recon_stack`

## Requirements
- R1: While and after synchronous reset, `cur_pc` equals parameter `RESET_PC`, `cur_mask` has every lane bit set, and `overflow` is 0; the base level has no reconvergence PC.
- R2: With `step_valid` high and no branch, the cycle after `cur_pc` becomes `step_pc` with `cur_mask` unchanged, unless a pop applies (R5).
- R3: A branch whose active lanes all take it moves `cur_pc` to `br_target`. A branch none of whose active lanes take it moves `cur_pc` to `br_fallthru`. In both cases nothing is pushed and `cur_mask` is unchanged.
- R4: A split branch (bit i of `br_taken` is lane i; the taken subset is `br_taken & cur_mask` and the other subset is `cur_mask & ~br_taken`, both non-zero) sets the current level's resume PC to `br_reconv`. It then pushes the fall-through path and, above it, the taken path, both tagged with `br_reconv`. The next cycle shows `br_target` under the taken subset.
- R5: When the top level's resume PC equals its valid reconvergence PC, that level is popped in the same update, and the outputs show the resume PC and mask of the level beneath.
- R6: After both paths of a split have reached the reconvergence PC, `cur_pc` equals `br_reconv` and `cur_mask` equals the mask that was active when the branch resolved.
- R7: On a split, a path whose start PC equals `br_reconv` is not pushed (for example an if without an else).
- R8: Several consecutive levels that all sit at their own reconvergence PC are popped in one cycle.
- R9: A split that needs more levels than remain free in the `DEPTH`-level stack sets `overflow`, and the push is dropped: `cur_pc`, `cur_mask` and the stack stay as they were. `overflow` stays set until reset.
- R10: When `br_valid` and `step_valid` are both high, the branch is applied and `step_pc` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | A non-branch instruction issued; `step_pc` is its successor |
| step_pc | input | PCW | PC following the instruction just fetched |
| br_valid | input | 1 | A branch resolved this cycle |
| br_taken | input | LANES | Per-lane taken outcome |
| br_target | input | PCW | Taken target PC |
| br_fallthru | input | PCW | Not-taken PC |
| br_reconv | input | PCW | Reconvergence PC (immediate post-dominator) |
| cur_pc | output | PCW | PC the warp executes next |
| cur_mask | output | LANES | Lanes active for that PC |
| overflow | output | 1 | Sticky flag: a split push was dropped |

## Verification
A corrupted level shows up only when it reaches the top. A wrong mask or resume PC in a waiting fall-through level therefore stays hidden until the taken path pops, which may be many cycles after the branch. The bench therefore drives full paths all the way to reconvergence, including nested and cascaded pops. It compares `cur_pc`, `cur_mask` and `overflow` against a queue model on every cycle. This catches a stale pointer or a missed pop at the first cycle in which it changes either output.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;

  // How the current branch relates to the active lanes
  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_ALL_NT = 2'd1,
    BR_ALL_T  = 2'd2,
    BR_SPLIT  = 2'd3
  } br_kind_e;

endpackage

// File: rtl/simt_div_classify.sv
module simt_div_classify
  import simt_stack_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PCW   = 16
) (
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic [PCW-1:0]   br_reconv,
  input  logic [LANES-1:0] act_mask,
  output br_kind_e         kind,
  output logic [LANES-1:0] t_mask,
  output logic [LANES-1:0] n_mask,
  output logic             push_t,
  output logic             push_n,
  output logic [1:0]       need
);

  always_comb begin
    t_mask = br_taken & act_mask;
    n_mask = act_mask & ~br_taken;
    if (!br_valid)            kind = BR_NONE;
    else if (t_mask == '0)    kind = BR_ALL_NT;
    else if (n_mask == '0)    kind = BR_ALL_T;
    else                      kind = BR_SPLIT;
    // a path that starts at the merge point has no work to do
    push_t = (kind == BR_SPLIT) && (br_target   != br_reconv);
    push_n = (kind == BR_SPLIT) && (br_fallthru != br_reconv);
    need   = {1'b0, push_t} + {1'b0, push_n};
  end

endmodule

// File: rtl/simt_pop_scan.sv
module simt_pop_scan #(
  parameter int DEPTH = 8,
  parameter int SPW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] at_merge,
  input  logic [SPW-1:0]   top,
  output logic [SPW-1:0]   pops
);

  // count consecutive merged levels from the top downward; level 0 never pops
  always_comb begin
    logic stop;
    pops = '0;
    stop = 1'b0;
    for (int j = DEPTH - 1; j >= 1; j--) begin
      if (j <= int'(top) && !stop) begin
        if (at_merge[j]) pops = pops + 1'b1;
        else             stop = 1'b1;
      end
    end
  end

endmodule

// File: rtl/simt_recon_stack.sv
module simt_recon_stack
  import simt_stack_pkg::*;
#(
  parameter int          LANES    = 4,
  parameter int          PCW      = 16,
  parameter int          DEPTH    = 8,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_valid,
  input  logic [PCW-1:0]   step_pc,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PCW-1:0]   br_target,
  input  logic [PCW-1:0]   br_fallthru,
  input  logic [PCW-1:0]   br_reconv,
  output logic [PCW-1:0]   cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic             overflow
);

  localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LANES-1:0] FULL = {LANES{1'b1}};

  // stack storage
  logic [PCW-1:0]   npc_q  [DEPTH];
  logic [PCW-1:0]   rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [DEPTH-1:0] rv_q;
  logic [SPW-1:0]   sp_q;

  logic [PCW-1:0]   npc_d  [DEPTH];
  logic [PCW-1:0]   rpc_d  [DEPTH];
  logic [LANES-1:0] mask_d [DEPTH];
  logic [DEPTH-1:0] rv_d;
  logic [SPW-1:0]   sp_mid, sp_fin, slot;
  logic [DEPTH-1:0] at_merge;
  logic [SPW-1:0]   pops;
  logic             ovf_evt;

  br_kind_e         kind;
  logic [LANES-1:0] t_mask, n_mask;
  logic             push_t, push_n;
  logic [1:0]       need;

  simt_div_classify #(.LANES(LANES), .PCW(PCW)) u_classify (
    .br_valid   (br_valid),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .br_fallthru(br_fallthru),
    .br_reconv  (br_reconv),
    .act_mask   (mask_q[sp_q]),
    .kind       (kind),
    .t_mask     (t_mask),
    .n_mask     (n_mask),
    .push_t     (push_t),
    .push_n     (push_n),
    .need       (need)
  );

  // apply the event to a copy of the stack
  always_comb begin
    npc_d   = npc_q;
    rpc_d   = rpc_q;
    mask_d  = mask_q;
    rv_d    = rv_q;
    sp_mid  = sp_q;
    slot    = sp_q;
    ovf_evt = 1'b0;
    unique case (kind)
      BR_SPLIT: begin
        if (int'(sp_q) + int'(need) > DEPTH - 1) begin
          ovf_evt = 1'b1;
        end else begin
          npc_d[sp_q] = br_reconv;
          if (push_n) begin
            slot         = slot + 1'b1;
            npc_d[slot]  = br_fallthru;
            rpc_d[slot]  = br_reconv;
            mask_d[slot] = n_mask;
            rv_d[slot]   = 1'b1;
          end
          if (push_t) begin
            slot         = slot + 1'b1;
            npc_d[slot]  = br_target;
            rpc_d[slot]  = br_reconv;
            mask_d[slot] = t_mask;
            rv_d[slot]   = 1'b1;
          end
          sp_mid = slot;
        end
      end
      BR_ALL_T:  npc_d[sp_q] = br_target;
      BR_ALL_NT: npc_d[sp_q] = br_fallthru;
      default: begin
        if (step_valid) npc_d[sp_q] = step_pc;
      end
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_merge
    assign at_merge[g] = rv_d[g] && (npc_d[g] == rpc_d[g]);
  end

  simt_pop_scan #(.DEPTH(DEPTH), .SPW(SPW)) u_pop_scan (
    .at_merge(at_merge),
    .top     (sp_mid),
    .pops    (pops)
  );

  assign sp_fin = sp_mid - pops;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        npc_q[i]  <= RESET_PC[PCW-1:0];
        rpc_q[i]  <= '0;
        mask_q[i] <= FULL;
      end
      rv_q     <= '0;
      sp_q     <= '0;
      cur_pc   <= RESET_PC[PCW-1:0];
      cur_mask <= FULL;
      overflow <= 1'b0;
    end else begin
      npc_q    <= npc_d;
      rpc_q    <= rpc_d;
      mask_q   <= mask_d;
      rv_q     <= rv_d;
      sp_q     <= sp_fin;
      cur_pc   <= npc_d[sp_fin];
      cur_mask <= mask_d[sp_fin];
      if (ovf_evt) overflow <= 1'b1;
    end
  end

  // assertions
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_drop_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ($stable(cur_pc) && $stable(cur_mask) && $stable(sp_q)));

  assert_split_partition_R4: assert property (@(posedge clk) disable iff (rst)
    (kind == BR_SPLIT) |-> (((t_mask & n_mask) == '0) && ((t_mask | n_mask) == cur_mask)
                            && (t_mask != '0) && (n_mask != '0)));

  assert_taken_first_R4: assert property (@(posedge clk) disable iff (rst)
    (kind == BR_SPLIT && !ovf_evt && push_t) |=>
      (cur_mask == $past(t_mask) && cur_pc == $past(br_target)));

  assert_uniform_mask_R3: assert property (@(posedge clk) disable iff (rst)
    (kind == BR_ALL_T || kind == BR_ALL_NT) && !at_merge[sp_q] |=> $stable(cur_mask));

  assert_base_level_R1: assert property (@(posedge clk) disable iff (rst)
    (sp_q == '0) |-> (cur_mask == FULL));

  assert_mask_live_R5: assert property (@(posedge clk) disable iff (rst)
    cur_mask != '0);

endmodule

// File: tb/test_simt_recon_stack.sv
module test_simt_recon_stack;

  localparam int          LANES = 4;
  localparam int          PCW   = 16;
  localparam int          DEPTH = 4;
  localparam logic [15:0] RPC0  = 16'h0100;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             step_valid = 1'b0;
  logic [PCW-1:0]   step_pc = '0;
  logic             br_valid = 1'b0;
  logic [LANES-1:0] br_taken = '0;
  logic [PCW-1:0]   br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic [PCW-1:0]   cur_pc;
  logic [LANES-1:0] cur_mask;
  logic             overflow;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simt_recon_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .RESET_PC(RPC0)) i_simt_recon_stack (
    .clk(clk), .rst(rst),
    .step_valid(step_valid), .step_pc(step_pc),
    .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .cur_pc(cur_pc), .cur_mask(cur_mask), .overflow(overflow)
  );

  // behavioural model: queue of levels, back is top
  typedef struct {
    bit          rv;
    logic [15:0] rpc;
    logic [15:0] npc;
    logic [3:0]  mask;
  } lvl_t;
  lvl_t mq[$];
  bit   m_ovf;

  task automatic model_reset();
    lvl_t b;
    b.rv = 0; b.rpc = '0; b.npc = RPC0; b.mask = 4'hF;
    mq = {};
    mq.push_back(b);
    m_ovf = 0;
  endtask

  task automatic model_step(input bit bv, input logic [3:0] tk, input logic [15:0] tg,
                            input logic [15:0] ft, input logic [15:0] rc,
                            input bit sv, input logic [15:0] sp);
    lvl_t top, e;
    logic [3:0] tm, nm;
    int need;
    top = mq[$];
    if (bv) begin
      tm = tk & top.mask;
      nm = top.mask & ~tk;
      if (tm == 0) mq[$].npc = ft;
      else if (nm == 0) mq[$].npc = tg;
      else begin
        need = (ft != rc ? 1 : 0) + (tg != rc ? 1 : 0);
        if (mq.size() + need > DEPTH) m_ovf = 1;
        else begin
          mq[$].npc = rc;
          if (ft != rc) begin e.rv = 1; e.rpc = rc; e.npc = ft; e.mask = nm; mq.push_back(e); end
          if (tg != rc) begin e.rv = 1; e.rpc = rc; e.npc = tg; e.mask = tm; mq.push_back(e); end
        end
      end
    end else if (sv) begin
      mq[$].npc = sp;
    end
    while (mq.size() > 1 && mq[$].rv && mq[$].npc == mq[$].rpc) void'(mq.pop_back());
  endtask

  task automatic compare(input string req);
    checks++;
    if (cur_pc !== mq[$].npc || cur_mask !== mq[$].mask || overflow !== m_ovf) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
               req, cur_pc, cur_mask, overflow, mq[$].npc, mq[$].mask, m_ovf);
    end
  endtask

  task automatic cyc(input string req, input bit bv, input logic [3:0] tk,
                     input logic [15:0] tg, input logic [15:0] ft, input logic [15:0] rc,
                     input bit sv, input logic [15:0] sp);
    br_valid = bv; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
    step_valid = sv; step_pc = sp;
    model_step(bv, tk, tg, ft, rc, sv, sp);
    @(posedge clk); #2;
    compare(req);
  endtask

  task automatic step(input string req, input logic [15:0] pc);
    cyc(req, 0, 4'h0, 16'h0, 16'h0, 16'h0, 1, pc);
  endtask

  task automatic branch(input string req, input logic [3:0] tk, input logic [15:0] tg,
                        input logic [15:0] ft, input logic [15:0] rc);
    cyc(req, 1, tk, tg, ft, rc, 0, 16'h0);
  endtask

  task automatic expect_out(input string req, input logic [15:0] pc, input logic [3:0] m,
                            input bit ov);
    checks++;
    if (cur_pc !== pc || cur_mask !== m || overflow !== ov) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
               req, cur_pc, cur_mask, overflow, pc, m, ov);
    end
  endtask

  task automatic do_reset();
    rst = 1; br_valid = 0; step_valid = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    expect_out("R1", RPC0, 4'hF, 0);
    rst = 0;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: pc=%h mask=%b ovf=%b expected run to finish", cur_pc, cur_mask, overflow);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    step("R1", 16'h0104);   expect_out("R2", 16'h0104, 4'hF, 0);
    // if/else: taken path first, then fall-through, then merge
    branch("R4", 4'b0110, 16'h0200, 16'h0110, 16'h0300);
    expect_out("R4", 16'h0200, 4'b0110, 0);
    step("R2", 16'h0204);   expect_out("R2", 16'h0204, 4'b0110, 0);
    step("R5", 16'h0300);   expect_out("R5", 16'h0110, 4'b1001, 0);
    step("R2", 16'h0114);
    step("R6", 16'h0300);   expect_out("R6", 16'h0300, 4'hF, 0);
    // uniform branches
    branch("R3", 4'b1111, 16'h0400, 16'h0304, 16'h0500);
    expect_out("R3", 16'h0400, 4'hF, 0);
    branch("R3", 4'b0000, 16'h0480, 16'h0404, 16'h0500);
    expect_out("R3", 16'h0404, 4'hF, 0);
    // if without else
    branch("R7", 4'b0011, 16'h0500, 16'h0600, 16'h0600);
    expect_out("R7", 16'h0500, 4'b0011, 0);
    step("R7", 16'h0600);   expect_out("R7", 16'h0600, 4'hF, 0);
    // nested split sharing the same merge point
    branch("R4", 4'b1100, 16'h0700, 16'h0780, 16'h0900);
    branch("R8", 4'b0100, 16'h0710, 16'h0900, 16'h0900);
    expect_out("R8", 16'h0710, 4'b0100, 0);
    step("R8", 16'h0900);   expect_out("R8", 16'h0780, 4'b0011, 0);
    step("R6", 16'h0900);   expect_out("R6", 16'h0900, 4'hF, 0);
    // both valid: branch wins
    cyc("R10", 1, 4'b1111, 16'h0A00, 16'h0904, 16'h0F00, 1, 16'h0B00);
    expect_out("R10", 16'h0A00, 4'hF, 0);
    // overflow: 3 levels used, second split needs 2 more
    branch("R9", 4'b0011, 16'h0C00, 16'h0C10, 16'h0D00);
    branch("R9", 4'b0001, 16'h0C40, 16'h0C50, 16'h0C80);
    expect_out("R9", 16'h0C00, 4'b0011, 1);
    step("R9", 16'h0C04);
    step("R9", 16'h0D00);
    expect_out("R9", 16'h0C10, 4'b1100, 1);
    // sticky until reset
    do_reset();
    expect_out("R9", RPC0, 4'hF, 0);
    // mixed random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a, b, c;
      a = 16'h0010 * $urandom_range(0, 5);
      b = 16'h0010 * $urandom_range(0, 5);
      c = 16'h0010 * $urandom_range(0, 5);
      if ($urandom_range(0, 3) == 0)
        cyc("R5", 1, 4'($urandom_range(0, 15)), a, b, c, $urandom_range(0, 1), c);
      else
        cyc("R2", 0, 4'h0, 16'h0, 16'h0, 16'h0, $urandom_range(0, 1), a);
      if (n == 300) do_reset();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule